// File: doc/BRIEF.md
# ECC Read Check and Correct Unit

This unit sits on the read return path of a memory controller. Each read brings a 64-bit data word and the 8-bit check code that was stored beside it. The unit rebuilds a check code from the data as read and XORs it with the stored code to form a syndrome. It then sorts the syndrome into one of four classes: clean, single-bit, nibble or double-bit. A single-bit error in a data bit is repaired by inverting that bit before the word is forwarded. All results appear one clock after the read is presented.

Uncorrectable results are handled according to the kind of read. On a plain read the word is flagged with a target-abort pulse. On a read that belongs to a read-modify-write, a sticky interrupt status bit is set instead. A corrected error also sets a sticky status bit, so that software can scrub the location. The address of the first faulting access is captured and held until software clears the status with a write-one-to-clear strobe. The interrupt line is high whenever any status bit is pending. An enable input turns checking off; the data then passes through untouched and has no side effects.

Top module: `ecc_rd_check`

## Requirements
- R1: A read presented with `rd_valid` high appears one clock later with `out_valid` high; with a zero syndrome `out_data` equals `rd_data` and `out_err` is 0 (encoding: 0 none, 1 single-bit, 2 nibble, 3 double-bit).
- R2: The column of data bit i is the i-th entry of a list built in two passes over the byte values 0xC1, 0xC2, … wrapping modulo 256 through 0xC0. The first pass takes the weight-3 values that are not confined to one nibble, and the second pass takes the weight-5 values. The column of check bit j is 1<<j. The syndrome is the stored code XOR the XOR of the columns of all set data bits.
- R3: A syndrome with odd weight that is not a nibble pattern gives `out_err`=1, and the data bit whose column equals the syndrome is inverted. Syndrome 0xC1 inverts data bit 0.
- R4: A syndrome with weight 1 (a check bit in error) gives `out_err`=1 with the data unchanged.
- R5: A syndrome with exactly three ones in one 4-bit half and zeroes in the other half gives `out_err`=2. This class takes precedence over the odd-weight rule.
- R6: Every other nonzero syndrome gives `out_err`=3.
- R7: An uncorrectable result (class 2 or 3) on a read with `rd_rmw` low raises `out_abort` together with `out_valid` for that word and sets no status bit.
- R8: An uncorrectable result on a read with `rd_rmw` high sets `int_status[2]` and leaves `out_abort` low.
- R9: A class-1 result sets `int_status[0]`. `int_status[1]` is never set. `irq` is high exactly when any `int_status` bit is set.
- R10: On any nonzero syndrome, `err_addr` captures `rd_addr` only if `int_status` was all zero before that read. Otherwise `err_addr` holds.
- R11: Each bit of `int_clr` clears the matching `int_status` bit. A new error that sets a bit in the same cycle wins over its clear.
- R12: With `ecc_en` low the data passes unchanged, with `out_err`=0, no abort, no status and no address capture.
- R13: Reset drives `out_valid`, `out_abort`, `int_status`, `irq` and `err_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Enable checking and correction |
| rd_valid | input | 1 | Read word present this cycle |
| rd_data | input | DATA_W | Data word as read from memory |
| rd_chk | input | 8 | Stored check code |
| rd_addr | input | ADDR_W | Address of the access |
| rd_rmw | input | 1 | Read belongs to a read-modify-write |
| int_clr | input | 3 | Write-one-to-clear strobes for `int_status` |
| out_valid | output | 1 | Forwarded word valid |
| out_data | output | DATA_W | Corrected or passed-through data |
| out_err | output | 2 | Error class of the forwarded word |
| out_abort | output | 1 | Target-abort for the forwarded word |
| int_status | output | 3 | Sticky status: bit 0 corrected, bit 2 uncorrectable in read-modify-write |
| err_addr | output | ADDR_W | Captured address of the first pending error |
| irq | output | 1 | Interrupt request, high while status is pending |

## Verification
Every one of the 64 data-bit flips and all 8 check-bit flips are swept over a nonzero base word. The data flips show whether each column of the matrix steers the repair to the right bit. The check-bit flips separate a correctable report from a data change. Nibble syndromes in both halves, adjacent double flips and a forced 0xC1 syndrome separate the nibble and double classes from the odd-weight class. Each uncorrectable class is applied with and without the read-modify-write flag, and in a disabled run, so that abort, status and pass-through can each be told apart. Address capture is probed with a second error while status is pending, and then again after a partial clear.

// File: rtl/ecc_rd_pkg.sv
package ecc_rd_pkg;

  localparam int unsigned CHK_W     = 8;
  localparam int unsigned COL_START = 193;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_NIBBLE = 2'd2,
    ERR_DOUBLE = 2'd3
  } ecc_err_e;

  function automatic int unsigned pop8(input logic [7:0] v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 8; b++) n += int'(v[b]);
    return n;
  endfunction

  function automatic logic nib_pattern(input logic [7:0] v);
    return ((v[7:4] == 4'h0) && (pop8({4'h0, v[3:0]}) == 3)) ||
           ((v[3:0] == 4'h0) && (pop8({4'h0, v[7:4]}) == 3));
  endfunction

  // Column of data bit idx: weight-3 non-nibble values, then weight-5 values,
  // both scanned from COL_START upward with wrap.
  function automatic logic [7:0] data_col(input int unsigned idx);
    int unsigned found;
    logic [7:0]  res;
    logic [7:0]  c;
    found = 0;
    res   = '0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 256; v++) begin
        c = 8'((COL_START + v) % 256);
        if ((pop8(c) == ((pass == 0) ? 3 : 5)) && !nib_pattern(c)) begin
          if (found == idx) res = c;
          found++;
        end
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_syn_gen.sv
module ecc_syn_gen
  import ecc_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk_stored,
  output logic [CHK_W-1:0]  syndrome
);

  logic [CHK_W-1:0] contrib [DATA_W];
  logic [CHK_W-1:0] regen;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = data_col(i);
    assign contrib[i] = data[i] ? COL : '0;
  end

  always_comb begin
    regen = '0;
    for (int i = 0; i < DATA_W; i++) regen = regen ^ contrib[i];
  end

  assign syndrome = regen ^ chk_stored;

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [CHK_W-1:0]  syndrome,
  output ecc_err_e          err_type,
  output logic [DATA_W-1:0] flip_mask
);

  logic odd_w;
  logic nib;
  logic single;

  assign odd_w = ^syndrome;
  assign nib   = nib_pattern(syndrome);

  always_comb begin
    if (syndrome == '0)  err_type = ERR_NONE;
    else if (nib)        err_type = ERR_NIBBLE;
    else if (odd_w)      err_type = ERR_SINGLE;
    else                 err_type = ERR_DOUBLE;
  end

  assign single = (err_type == ERR_SINGLE);

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [CHK_W-1:0] COL = data_col(i);
    assign flip_mask[i] = single && (syndrome == COL);
  end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  ecc_err_e          ev_type,
  input  logic              ev_rmw,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [2:0]        clr,
  output logic [2:0]        status,
  output logic [ADDR_W-1:0] addr_q,
  output logic              irq
);

  logic [2:0] st_n;
  logic       uncorr;

  assign uncorr = (ev_type == ERR_NIBBLE) || (ev_type == ERR_DOUBLE);

  always_comb begin
    st_n = status & ~clr;
    if (ev_valid && (ev_type == ERR_SINGLE)) st_n[0] = 1'b1;
    if (ev_valid && uncorr && ev_rmw)        st_n[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      addr_q <= '0;
      irq    <= 1'b0;
    end else begin
      status <= st_n;
      irq    <= |st_n;
      if (ev_valid && (ev_type != ERR_NONE) && (status == '0))
        addr_q <= ev_addr;
    end
  end

endmodule

// File: rtl/ecc_rd_check.sv
module ecc_rd_check
  import ecc_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_en,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [7:0]        rd_chk,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rmw,
  input  logic [2:0]        int_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_err,
  output logic              out_abort,
  output logic [2:0]        int_status,
  output logic [ADDR_W-1:0] err_addr,
  output logic              irq
);

  logic [CHK_W-1:0]  syndrome;
  ecc_err_e          err_type;
  logic [DATA_W-1:0] flip_mask;
  logic              uncorr;
  logic              ev_valid;

  ecc_syn_gen #(.DATA_W(DATA_W)) u_syn (
    .data       (rd_data),
    .chk_stored (rd_chk),
    .syndrome   (syndrome)
  );

  ecc_classify #(.DATA_W(DATA_W)) u_cls (
    .syndrome  (syndrome),
    .err_type  (err_type),
    .flip_mask (flip_mask)
  );

  assign ev_valid = rd_valid && ecc_en;
  assign uncorr   = (err_type == ERR_NIBBLE) || (err_type == ERR_DOUBLE);

  ecc_err_log #(.ADDR_W(ADDR_W)) u_log (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .ev_type  (err_type),
    .ev_rmw   (rd_rmw),
    .ev_addr  (rd_addr),
    .clr      (int_clr),
    .status   (int_status),
    .addr_q   (err_addr),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= ERR_NONE;
      out_abort <= 1'b0;
    end else begin
      out_valid <= rd_valid;
      out_abort <= ev_valid && uncorr && !rd_rmw;
      if (rd_valid) begin
        out_data <= ecc_en ? (rd_data ^ flip_mask) : rd_data;
        out_err  <= ecc_en ? err_type : ERR_NONE;
      end
    end
  end

endmodule

// File: rtl/ecc_rd_check_chk.sv
module ecc_rd_check_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ecc_en,
  input logic              rd_valid,
  input logic              rd_rmw,
  input logic [2:0]        int_clr,
  input logic              out_valid,
  input logic [1:0]        out_err,
  input logic              out_abort,
  input logic [2:0]        int_status,
  input logic [ADDR_W-1:0] err_addr,
  input logic              irq
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> out_valid);

  a_r7_abort_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_abort |-> out_valid);

  a_r8_no_abort_in_rmw: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_rmw) |=> !out_abort);

  a_r9_irq_tracks_status: assert property (@(posedge clk) disable iff (rst)
    irq == (int_status != 3'b000));

  a_r9_bit1_never_set: assert property (@(posedge clk) disable iff (rst)
    !int_status[1]);

  a_r10_addr_holds: assert property (@(posedge clk) disable iff (rst)
    (int_status != 3'b000) |=> $stable(err_addr));

  a_r12_bypass_quiet: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !ecc_en) |=> (out_err == 2'd0 && !out_abort));

  a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (int_clr[0] && !(rd_valid && ecc_en)) |=> !int_status[0]);

endmodule

bind ecc_rd_check ecc_rd_check_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ecc_en     (ecc_en),
  .rd_valid   (rd_valid),
  .rd_rmw     (rd_rmw),
  .int_clr    (int_clr),
  .out_valid  (out_valid),
  .out_err    (out_err),
  .out_abort  (out_abort),
  .int_status (int_status),
  .err_addr   (err_addr),
  .irq        (irq)
);

// File: tb/ecc_rd_check_bench.sv
module ecc_rd_check_bench;

  localparam int DW = 64;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ecc_en = 1'b1;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [7:0]    rd_chk = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_rmw = 1'b0;
  logic [2:0]    int_clr = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [1:0]    out_err;
  logic          out_abort;
  logic [2:0]    int_status;
  logic [AW-1:0] err_addr;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] cols [DW];

  ecc_rd_check #(.DATA_W(DW), .ADDR_W(AW)) u_ecc_rd_check (
    .clk(clk), .rst(rst), .ecc_en(ecc_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_chk(rd_chk), .rd_addr(rd_addr), .rd_rmw(rd_rmw),
    .int_clr(int_clr), .out_valid(out_valid), .out_data(out_data),
    .out_err(out_err), .out_abort(out_abort), .int_status(int_status),
    .err_addr(err_addr), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic int wt(input logic [7:0] v);
    int n = 0;
    for (int b = 0; b < 8; b++) if (v[b]) n++;
    return n;
  endfunction

  function automatic logic [7:0] code_of(input logic [DW-1:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < DW; i++) if (d[i]) c ^= cols[i];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one read on a falling edge, sample after the next rising edge.
  task automatic apply(input logic [DW-1:0] d, input logic [7:0] c,
                       input logic [AW-1:0] a, input logic rmw,
                       input logic [2:0] clr);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; rd_chk = c; rd_addr = a; rd_rmw = rmw;
    int_clr = clr;
    @(negedge clk);
    rd_valid = 1'b0; int_clr = '0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    int_clr = 3'b111;
    @(negedge clk);
    int_clr = '0;
  endtask

  // Build the column list from R2, independently of the design.
  initial begin
    int k = 0;
    for (int pass = 0; pass < 2; pass++)
      for (int v = 0; v < 256; v++) begin
        logic [7:0] c;
        bit nib;
        c = 8'((193 + v) % 256);
        nib = (c[7:4] == 0 && wt(c) == 3) || (c[3:0] == 0 && wt(c) == 3);
        if (wt(c) == (pass == 0 ? 3 : 5) && !nib && k < DW) begin
          cols[k] = c; k++;
        end
      end
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  localparam logic [DW-1:0] BASE = 64'h0123_4567_89AB_CDEF;

  initial begin
    logic [DW-1:0] pats [5];
    pats[0] = '0; pats[1] = '1; pats[2] = 64'hA5A5_5A5A_F00F_0FF0;
    pats[3] = BASE; pats[4] = 64'h8000_0000_0000_0001;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(out_valid == 0 && out_abort == 0, "R13 valid/abort", {out_valid, out_abort}, 0);
    check(int_status == 0 && irq == 0, "R13 status/irq", {int_status, irq}, 0);
    check(err_addr == 0, "R13 err_addr", err_addr, 0);

    // R1 clean words
    for (int p = 0; p < 5; p++) begin
      apply(pats[p], code_of(pats[p]), 32'h100 + p, 0, 0);
      check(out_valid && out_data == pats[p], "R1 data", out_data, pats[p]);
      check(out_err == 0 && !out_abort && !irq, "R1 class", out_err, 0);
    end

    // R2 R3 R9 every data bit flipped
    for (int i = 0; i < DW; i++) begin
      clear_all();
      apply(BASE ^ (64'd1 << i), code_of(BASE), 32'h2000 + i, 0, 0);
      check(out_data == BASE, "R3 corrected data", out_data, BASE);
      check(out_err == 1 && !out_abort, "R3 class", out_err, 1);
      check(int_status == 3'b001 && irq, "R9 status", {int_status, irq}, 4'b0011);
      check(err_addr == 32'h2000 + i, "R10 capture", err_addr, 32'h2000 + i);
    end

    // R4 check-bit errors
    for (int j = 0; j < 8; j++) begin
      clear_all();
      apply(BASE, code_of(BASE) ^ (8'd1 << j), 0, 0, 0);
      check(out_data == BASE && out_err == 1, "R4 check bit", {out_err, out_data}, {2'd1, BASE});
    end

    // R3 syndrome 0xC1 hits bit 0
    clear_all();
    apply(BASE, code_of(BASE) ^ 8'hC1, 0, 0, 0);
    check(out_data == (BASE ^ 64'd1), "R3 syndrome C1", out_data, BASE ^ 64'd1);

    // R5 R7 nibble, plain read
    clear_all();
    apply(BASE, code_of(BASE) ^ 8'h07, 32'h300, 0, 0);
    check(out_err == 2 && out_abort && out_valid, "R5 nibble low", {out_err, out_abort}, 3'b101);
    check(int_status == 0 && !irq, "R7 no status", {int_status, irq}, 0);
    check(out_data == BASE, "R5 data untouched", out_data, BASE);
    check(err_addr == 32'h300, "R10 abort capture", err_addr, 32'h300);
    apply(BASE, code_of(BASE) ^ 8'hE0, 0, 0, 0);
    check(out_err == 2 && out_abort, "R5 nibble high", {out_err, out_abort}, 3'b101);

    // R8 nibble in read-modify-write
    apply(BASE, code_of(BASE) ^ 8'h0B, 32'h400, 1, 0);
    check(out_err == 2 && !out_abort, "R8 no abort", {out_err, out_abort}, 3'b100);
    check(int_status == 3'b100 && irq, "R8 status", {int_status, irq}, 4'b1001);
    check(err_addr == 32'h400, "R10 rmw capture", err_addr, 32'h400);

    // R6 double errors
    for (int i = 0; i < DW - 1; i += 9) begin
      clear_all();
      apply(BASE ^ (64'd3 << i), code_of(BASE), 0, 0, 0);
      check(out_err == 3 && out_abort, "R6 double", {out_err, out_abort}, 3'b111);
      apply(BASE ^ (64'd3 << i), code_of(BASE), 0, 1, 0);
      check(out_err == 3 && int_status == 3'b100, "R6 double rmw", {out_err, int_status}, 5'b11100);
    end

    // R10 hold while pending, R11 partial clear and set-wins
    clear_all();
    apply(BASE ^ 64'd2, code_of(BASE), 32'hA1, 0, 0);
    apply(BASE ^ 64'd4, code_of(BASE), 32'hA2, 0, 0);
    check(err_addr == 32'hA1, "R10 hold", err_addr, 32'hA1);
    apply(BASE, code_of(BASE) ^ 8'h07, 32'hA3, 1, 0);
    check(int_status == 3'b101, "R11 both set", int_status, 3'b101);
    apply(0, 0, 0, 0, 3'b100);
    check(int_status == 3'b001 && irq, "R11 partial clear", {int_status, irq}, 4'b0011);
    apply(BASE ^ 64'd8, code_of(BASE), 32'hA4, 0, 3'b001);
    check(int_status == 3'b001, "R11 set wins", int_status, 3'b001);
    check(err_addr == 32'hA1, "R10 still held", err_addr, 32'hA1);
    apply(0, 0, 0, 0, 3'b001);
    check(int_status == 0 && !irq, "R11 cleared", {int_status, irq}, 0);
    apply(BASE ^ 64'd16, code_of(BASE), 32'hA5, 0, 0);
    check(err_addr == 32'hA5, "R10 recapture", err_addr, 32'hA5);

    // R12 disabled bypass
    clear_all();
    ecc_en = 1'b0;
    apply(BASE ^ 64'd3, code_of(BASE), 32'hB0, 1, 0);
    check(out_data == (BASE ^ 64'd3) && out_err == 0, "R12 passthrough", out_data, BASE ^ 64'd3);
    check(!out_abort && int_status == 0 && !irq, "R12 quiet", {out_abort, int_status, irq}, 0);
    apply(BASE ^ 64'd1, code_of(BASE), 32'hB1, 0, 0);
    check(out_data == (BASE ^ 64'd1) && int_status == 0, "R12 single ignored", out_data, BASE ^ 64'd1);
    check(err_addr == 32'hA5, "R12 no capture", err_addr, 32'hA5);
    ecc_en = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule